// File: doc/BRIEF.md
# Streaming 3x3 Convolution Window Controller

This block keeps a 3x3 convolution pipeline busy on every clock. It reads three image lines in parallel from three show-ahead line-buffer ports. Each port presents its next unread pixel, and a high `line_rd_en` at a clock edge consumes that pixel from all three lines. The block shifts each column it reads into a 3x3 window register. It feeds the window to a three-stage multiply-accumulate pipeline that holds a fixed signed kernel, and marks every real result with a valid strobe.

A one-cycle `start` in idle begins a line. The block first fills the window with three columns. It then reads one column and issues one window on every cycle until the whole line has been consumed. A final window is issued without a read. The block then drains the pipeline and pulses `done`. Any line port that reports empty during fill or streaming holds the whole datapath until data returns. The line width is a parameter, and each line yields width minus two output pixels.

Top module: `conv_stream_ctrl`

## Requirements
- R1: While `rst` is high and on the cycle after it is released, `pix_valid`, `done` and `line_rd_en` are all low and `pix_out` is 0.
- R2: A `start` sampled in idle at edge s causes reads at edges s+1, s+2 and s+3. These fill the window. The first `pix_valid` is seen after edge s+6.
- R3: When no line port is empty, reads occur on every cycle and outputs come on consecutive cycles, with no idle cycle between pixels of one line.
- R4: While any bit of `line_empty` is high during fill or streaming, `line_rd_en` stays low and the window is held. The results of the line are unchanged and arrive later by the number of stalled cycles.
- R5: Each output equals the sum, over rows r and columns c, of K[r][c] times pixel[r][j+c] for window j. Row r arrives on `line_rd_data[8r+7:8r]`. Column c=0 is the oldest pixel. K is {0,-1,0},{-1,5,-1},{0,-1,0}. The output appears three edges after the window is issued.
- R6: A sum below 0 is output as 0, and a sum above 255 is output as 255.
- R7: Exactly WIDTH-2 valid pixels are produced per line. `done` is high for one cycle, in the cycle after the last valid pixel. With no stall this is after edge s+WIDTH+4.
- R8: A `start` while a line is in progress has no effect on outputs, read count or `done`.
- R9: Exactly WIDTH reads are made per line, and no read is made after the line's last column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin processing one line (sampled in idle only) |
| line_empty | input | 3 | Per-line empty flag of the three read ports |
| line_rd_data | input | 24 | Head pixel of each line, row r in bits 8r+7:8r |
| line_rd_en | output | 1 | Consume the head pixel of all three lines |
| pix_out | output | 8 | Clamped convolution result |
| pix_valid | output | 1 | pix_out carries a real result |
| done | output | 1 | One-cycle pulse after the last result of a line |

## Verification
All timing is referred to the edge s that samples `start`. The first result is due after edge s+6. The last result is due after edge s+WIDTH+3, and `done` one cycle later. A stall shifts these by exactly the number of held cycles. The bench counts edges and samples every output on the falling edge. It records the edge index of each valid pixel and of `done`, and compares each index with these offsets and each pixel value with a sum computed from the stored line contents. Read strobes are counted in the same way, so an extra read, a missing read or a read into an empty port shows up as a count mismatch.

// File: rtl/conv_pkg.sv
package conv_pkg;
  localparam int KDIM   = 3;
  localparam int KTAPS  = KDIM * KDIM;
  localparam int COEF_W = 8;

  typedef logic signed [COEF_W-1:0] coef_t;
  typedef coef_t [KTAPS-1:0] kern_t;

  // symmetric sharpening kernel, tap index = row*KDIM + col
  localparam kern_t KERN_SHARPEN = {8'h00, 8'hFF, 8'h00,
                                    8'hFF, 8'h05, 8'hFF,
                                    8'h00, 8'hFF, 8'h00};

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_FILL,
    CS_STREAM,
    CS_LAST,
    CS_DRAIN
  } ctrl_st_t;
endpackage

// File: rtl/conv_win_shift.sv
module conv_win_shift
  import conv_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  shift_en,
  input  logic [KDIM*PW-1:0]    col_in,
  output logic [KTAPS*PW-1:0]   win
);
  logic [PW-1:0] tap_q [KDIM][KDIM];

  for (genvar r = 0; r < KDIM; r++) begin : g_row
    for (genvar c = 0; c < KDIM; c++) begin : g_col
      if (c == KDIM-1) begin : g_new
        always_ff @(posedge clk) begin
          if (rst)           tap_q[r][c] <= '0;
          else if (shift_en) tap_q[r][c] <= col_in[r*PW +: PW];
        end
      end else begin : g_old
        always_ff @(posedge clk) begin
          if (rst)           tap_q[r][c] <= '0;
          else if (shift_en) tap_q[r][c] <= tap_q[r][c+1];
        end
      end
      assign win[(r*KDIM+c)*PW +: PW] = tap_q[r][c];
    end
  end

  // R4: window contents hold when no column is shifted in
  a_r4_window_hold: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(win));
endmodule

// File: rtl/conv_mac3.sv
module conv_mac3
  import conv_pkg::*;
#(
  parameter int    PW     = 8,
  parameter kern_t KERNEL = KERN_SHARPEN
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [KTAPS*PW-1:0] win,
  output logic [PW-1:0]       pix_out
);
  localparam int PRW = PW + 1 + COEF_W;
  localparam int RSW = PRW + 2;
  localparam int TW  = RSW + 2;
  localparam logic signed [TW-1:0] PMAX = TW'((1 << PW) - 1);

  logic signed [PRW-1:0] prod_q [KTAPS];
  logic signed [RSW-1:0] row_q  [KDIM];
  logic signed [TW-1:0]  total;

  // stage 1: products
  for (genvar t = 0; t < KTAPS; t++) begin : g_prod
    always_ff @(posedge clk) begin
      if (rst) prod_q[t] <= '0;
      else     prod_q[t] <= $signed({1'b0, win[t*PW +: PW]}) * $signed(KERNEL[t]);
    end
  end

  // stage 2: per-row partial sums
  for (genvar r = 0; r < KDIM; r++) begin : g_rsum
    logic signed [RSW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int c = 0; c < KDIM; c++) acc = acc + RSW'(prod_q[r*KDIM+c]);
    end
    always_ff @(posedge clk) begin
      if (rst) row_q[r] <= '0;
      else     row_q[r] <= acc;
    end
  end

  always_comb begin
    total = '0;
    for (int r = 0; r < KDIM; r++) total = total + TW'(row_q[r]);
  end

  // stage 3: sum and clamp
  always_ff @(posedge clk) begin
    if (rst)                pix_out <= '0;
    else if (total < 0)     pix_out <= '0;
    else if (total > PMAX)  pix_out <= '1;
    else                    pix_out <= total[PW-1:0];
  end
endmodule

// File: rtl/conv_ctrl_fsm.sv
module conv_ctrl_fsm
  import conv_pkg::*;
#(
  parameter int WIDTH = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic any_empty,
  output logic rd_en,
  output logic issue,
  output logic vld_out,
  output logic done
);
  localparam int CW  = $clog2(WIDTH + 1);
  localparam int PIPE = 3;

  ctrl_st_t        st;
  logic [1:0]      fill_cnt;
  logic [CW-1:0]   col;
  logic [PIPE-1:0] vld_q;

  always_comb begin
    rd_en = ((st == CS_FILL) || (st == CS_STREAM)) && !any_empty;
    issue = ((st == CS_STREAM) && !any_empty) || (st == CS_LAST);
  end

  assign vld_out = vld_q[PIPE-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= CS_IDLE;
      fill_cnt <= '0;
      col      <= '0;
      vld_q    <= '0;
      done     <= 1'b0;
    end else begin
      done  <= 1'b0;
      vld_q <= {vld_q[PIPE-2:0], issue};
      case (st)
        CS_IDLE: if (start) begin
          st       <= CS_FILL;
          fill_cnt <= '0;
          col      <= '0;
        end
        CS_FILL: if (rd_en) begin
          col <= col + 1'b1;
          if (fill_cnt == 2'd2) begin
            st       <= CS_STREAM;
            fill_cnt <= '0;
          end else begin
            fill_cnt <= fill_cnt + 1'b1;
          end
        end
        CS_STREAM: if (rd_en) begin
          col <= col + 1'b1;
          if (col == CW'(WIDTH - 1)) st <= CS_LAST;
        end
        CS_LAST:  st <= CS_DRAIN;
        CS_DRAIN: if (vld_q == 3'b100) begin
          done <= 1'b1;
          st   <= CS_IDLE;
        end
        default: st <= CS_IDLE;
      endcase
    end
  end

  // R2: streaming begins right after the third fill read
  a_r2_fill_three: assert property (@(posedge clk) disable iff (rst)
    (st == CS_FILL && rd_en && fill_cnt == 2'd2) |=> (st == CS_STREAM && col == CW'(3)));

  // R9: the read count of a line never exceeds the width
  a_r9_no_overread: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> col < CW'(WIDTH));
endmodule

// File: rtl/conv_stream_ctrl.sv
module conv_stream_ctrl
  import conv_pkg::*;
#(
  parameter int    WIDTH  = 512,
  parameter int    PW     = 8,
  parameter kern_t KERNEL = KERN_SHARPEN
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [KDIM-1:0]      line_empty,
  input  logic [KDIM*PW-1:0]   line_rd_data,
  output logic                 line_rd_en,
  output logic [PW-1:0]        pix_out,
  output logic                 pix_valid,
  output logic                 done
);
  localparam int CW = $clog2(WIDTH + 1);

  logic                rd_en;
  logic                issue;
  logic [KTAPS*PW-1:0] win;

  conv_ctrl_fsm #(.WIDTH(WIDTH)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .any_empty (|line_empty),
    .rd_en     (rd_en),
    .issue     (issue),
    .vld_out   (pix_valid),
    .done      (done)
  );

  conv_win_shift #(.PW(PW)) u_win (
    .clk      (clk),
    .rst      (rst),
    .shift_en (rd_en),
    .col_in   (line_rd_data),
    .win      (win)
  );

  conv_mac3 #(.PW(PW), .KERNEL(KERNEL)) u_mac (
    .clk     (clk),
    .rst     (rst),
    .win     (win),
    .pix_out (pix_out)
  );

  assign line_rd_en = rd_en;

  // result counter used by the checks below
  logic [CW-1:0] n_valid;
  always_ff @(posedge clk) begin
    if (rst || done)    n_valid <= '0;
    else if (pix_valid) n_valid <= n_valid + 1'b1;
  end

  // R5: every valid result was issued three edges earlier
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> $past(issue, 3));

  // R7: a line ends with exactly WIDTH-2 results
  a_r7_count: assert property (@(posedge clk) disable iff (rst)
    done |-> n_valid == CW'(WIDTH - 2));

  // R7: done follows the last result directly
  a_r7_done_after: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(pix_valid) && !pix_valid));
endmodule

// File: tb/sim_conv_stream_ctrl.sv
`timescale 1ns/1ps
module sim_conv_stream_ctrl;
  localparam int W = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  line_empty;
  logic [23:0] line_rd_data;
  logic        line_rd_en;
  logic [7:0]  pix_out;
  logic        pix_valid;
  logic        done;

  always #2.5 clk = ~clk;

  conv_stream_ctrl #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .start(start), .line_empty(line_empty),
    .line_rd_data(line_rd_data), .line_rd_en(line_rd_en),
    .pix_out(pix_out), .pix_valid(pix_valid), .done(done)
  );

  // line buffer model
  int line_px [3][W];
  int ptr = 0;
  logic [2:0] stall_mask = 3'b000;
  int cyc = 0;

  always_comb begin
    for (int r = 0; r < 3; r++) begin
      line_empty[r] = (ptr >= W) || stall_mask[r];
      line_rd_data[r*8 +: 8] = (ptr < W) ? 8'(line_px[r][ptr]) : 8'h00;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (line_rd_en && ptr < W) ptr <= ptr + 1;
  end

  // monitor
  int out_v [64];
  int out_c [64];
  int n_out = 0, done_cnt = 0, done_cyc = 0, reads = 0, bad_reads = 0;
  int n_chk = 0, n_fail = 0;
  int kb [9] = '{0, -1, 0, -1, 5, -1, 0, -1, 0};

  always @(negedge clk) begin
    if (!rst) begin
      if (pix_valid && n_out < 64) begin
        out_v[n_out] = int'(pix_out);
        out_c[n_out] = cyc;
        n_out++;
      end
      if (done) begin done_cnt++; done_cyc = cyc; end
      if (line_rd_en) begin
        reads++;
        if (|line_empty) bad_reads++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expv(input int j);
    int s = 0;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++)
        s += kb[r*3+c] * line_px[r][j+c];
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  function automatic int raw_sum(input int j);
    int s = 0;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++)
        s += kb[r*3+c] * line_px[r][j+c];
    return s;
  endfunction

  // start a line; optional stall on line 1 and optional extra start pulse
  task automatic run_line(input int stall_len, input bit extra_start, output int s);
    n_out = 0; done_cnt = 0; reads = 0; bad_reads = 0; ptr = 0;
    @(negedge clk);
    start = 1'b1;
    s = cyc + 1;
    @(negedge clk);
    start = 1'b0;
    while (cyc < s + 5) @(negedge clk);
    if (stall_len > 0) begin
      stall_mask = 3'b010;
      repeat (stall_len) @(negedge clk);
      stall_mask = 3'b000;
    end
    if (extra_start) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int t = 0; t < 200 && done_cnt == 0; t++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic verify_line(input int s, input int stall_len, input string tag);
    chk(n_out == W-2, "R7 result count", n_out, W-2);
    chk(done_cnt == 1, "R7 single done", done_cnt, 1);
    chk(done_cyc == s + W + 4 + stall_len, "R7 done timing", done_cyc, s + W + 4 + stall_len);
    chk(reads == W, "R9 read count", reads, W);
    chk(bad_reads == 0, "R4 read while empty", bad_reads, 0);
    if (n_out > 0) chk(out_c[0] == s + 6, "R2 first result edge", out_c[0], s + 6);
    for (int i = 0; i < n_out && i < W-2; i++)
      chk(out_v[i] == expv(i), tag, out_v[i], expv(i));
    if (stall_len == 0)
      for (int i = 1; i < n_out; i++)
        chk(out_c[i] == out_c[0] + i, "R3 back-to-back results", out_c[i], out_c[0] + i);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!pix_valid && !done && !line_rd_en && pix_out == 0, "R1 outputs during reset",
        {pix_valid, done, line_rd_en}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!pix_valid && !done && !line_rd_en && pix_out == 0, "R1 outputs after reset",
        {pix_valid, done, line_rd_en}, 0);
  endtask

  task automatic t_basic();
    int s;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < W; c++)
        line_px[r][c] = (r*37 + c*23 + 11) % 256;
    run_line(0, 1'b0, s);
    verify_line(s, 0, "R5 pixel value basic");
  endtask

  task automatic t_ramp();
    int s;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < W; c++)
        line_px[r][c] = (c*29 + r*r*51) % 256;
    run_line(0, 1'b0, s);
    verify_line(s, 0, "R5 pixel value ramp");
  endtask

  task automatic t_clamp();
    int s, hi, lo;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < W; c++)
        line_px[r][c] = (r == 1) ? ((c % 2) ? 255 : 0) : 0;
    line_px[0][3] = 200;
    run_line(0, 1'b0, s);
    verify_line(s, 0, "R6 clamped value");
    hi = 0; lo = 0;
    for (int j = 0; j < W-2; j++) begin
      if (raw_sum(j) > 255) hi++;
      if (raw_sum(j) < 0) lo++;
    end
    chk(hi > 0 && lo > 0, "R6 pattern covers both limits", hi*100 + lo, 101);
  endtask

  task automatic t_stall();
    int s;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < W; c++)
        line_px[r][c] = (r*90 + c*17 + 5) % 256;
    run_line(3, 1'b0, s);
    verify_line(s, 3, "R4 value after stall");
  endtask

  task automatic t_busy_start();
    int s;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < W; c++)
        line_px[r][c] = (r*13 + c*61 + 7) % 256;
    run_line(0, 1'b1, s);
    verify_line(s, 0, "R8 value with start while busy");
    chk(n_out == W-2 && done_cnt == 1, "R8 busy start ignored", n_out, W-2);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(5ns * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    t_reset();
    t_basic();
    t_ramp();
    t_clamp();
    t_stall();
    t_busy_start();
    t_basic();
    summary();
  end
endmodule